// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

The block is a small processor that fetches, decodes, executes and retires one instruction in each clock cycle. It covers a compact integer subset: word load and store, five register-to-register operations (add, subtract, AND, OR, signed set-on-less-than), a branch-if-equal and an absolute jump. It holds a program counter, a 32-entry register file, an instruction memory and a data memory. Both memories are word arrays inside the block, and the testbench preloads them before reset is released.

Decoding is done in two levels. A main decoder maps the 6-bit opcode to datapath selects and a 2-bit ALU class. A second decoder combines that class with the function field of register-format instructions to pick the ALU operation. Debug outputs show the current PC and the register write-back of the instruction that is retiring in the present cycle.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and every register reads as 0.
- R2: pc_o stays word aligned. Every instruction other than a taken branch or a jump sets the next PC to PC+4.
- R3: Opcode 0 is register format with fields rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. Funct 0x20 gives add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A signed less-than (result 1 or 0). The result is written to rd.
- R4: Opcode 35 loads the data word at byte address rs + sign-extended imm [15:0] into rt.
- R5: Opcode 43 stores rt at byte address rs + sign-extended imm [15:0]. It writes no register.
- R6: Opcode 4 compares rs and rt. When they are equal, the next PC is PC+4 + (sign-extended imm << 2); otherwise it is PC+4. It writes no register.
- R7: Opcode 2 sets the next PC to {PC[31:28], instr[25:0], 2'b00}.
- R8: Register 0 always reads as 0. A write aimed at it is dropped, and wb_en_o stays low for it.
- R9: Any other opcode writes nothing and advances the PC by 4.
- R10: wb_en_o, wb_addr_o and wb_data_o show the register write that takes effect at the next rising edge. The source operands are read before that write, so an instruction may read and write the same register in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| wb_en_o | output | 1 | A register write retires at the next edge |
| wb_addr_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value being written |

## Verification
In a single cycle, the register file is read for operands and written with the result, and the same register can be on both sides. Accumulating instructions such as `add r9,r9,r1` and `add r10,r10,r11` bring this about: each reads the old value and writes the new one in the same cycle. A bench-side instruction model predicts wb_data_o from the value the register held before the edge. The store and load that follow each other at the same address check a memory write in one cycle against a read in the next. A sweep of operand pairs, some equal and some negative, exercises both branch outcomes and signed comparison.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JMP   = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_op_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_ctrl_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{default: '0, alu_op: AOP_ADD};
    case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_op    = AOP_FUNCT;
      end
      OP_LW: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_read   = 1'b1;
      end
      OP_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = AOP_SUB;
      end
      OP_JMP: ctrl_o.jump = 1'b1;
      default: ;  // unknown opcode: no side effects
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  alu_op_e    alu_op_i,
  input  logic [5:0] funct_i,
  output alu_ctrl_e  alu_ctrl_o
);
  always_comb begin
    alu_ctrl_o = ALU_ADD;
    case (alu_op_i)
      AOP_SUB: alu_ctrl_o = ALU_SUB;
      AOP_FUNCT: begin
        case (funct_i)
          FN_SUB:  alu_ctrl_o = ALU_SUB;
          FN_AND:  alu_ctrl_o = ALU_AND;
          FN_OR:   alu_ctrl_o = ALU_OR;
          FN_SLT:  alu_ctrl_o = ALU_SLT;
          default: alu_ctrl_o = ALU_ADD;
        endcase
      end
      default: alu_ctrl_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_ctrl_e      ctrl_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o,
  output logic           zero_o
);
  always_comb begin
    case (ctrl_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  da_o,
  output logic [W-1:0]  db_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [DEPTH];

  assign regs_q[0] = '0;

  for (genvar g = 1; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       regs_q[g] <= '0;
      else if (we_i && wa_i == AW'(g))   regs_q[g] <= wd_i;
    end
  end

  assign da_o = regs_q[ra_i];
  assign db_o = regs_q[rb_i];
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic         clk_i,
  input  logic [W-1:0] addr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] mem_q [WORDS];
  logic [IW-1:0] idx;
  logic          unused_addr;

  assign idx         = addr_i[IW+1:2];
  assign unused_addr = ^{addr_i[1:0], addr_i[W-1:IW+2]};

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx] <= wdata_i;
  end

  assign rdata_o = mem_q[idx];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [XLEN-1:0]   pc_o,
  output logic              wb_en_o,
  output logic [RIDX_W-1:0] wb_addr_o,
  output logic [XLEN-1:0]   wb_data_o
);
  logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_tgt, j_tgt;
  logic [XLEN-1:0]   instr, imm_sext;
  logic [5:0]        opcode, funct;
  logic [RIDX_W-1:0] rs, rt, rd, wb_addr;
  logic [XLEN-1:0]   rs_val, rt_val, alu_b, alu_y, mem_rd, wb_data;
  logic              alu_zero;
  ctrl_t             ctrl;
  alu_ctrl_e         alu_ctrl;

  sc_mem #(.W(XLEN), .WORDS(IMEM_WORDS)) u_imem (
    .clk_i, .addr_i(pc_q), .we_i(1'b0), .wdata_i('0), .rdata_o(instr)
  );

  assign opcode   = instr[31:26];
  assign rs       = instr[25:21];
  assign rt       = instr[20:16];
  assign rd       = instr[15:11];
  assign funct    = instr[5:0];
  assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_main_dec u_main_dec (.opcode_i(opcode), .ctrl_o(ctrl));
  sc_alu_dec  u_alu_dec  (.alu_op_i(ctrl.alu_op), .funct_i(funct), .alu_ctrl_o(alu_ctrl));

  sc_regfile #(.W(XLEN), .DEPTH(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra_i(rs), .rb_i(rt), .da_o(rs_val), .db_o(rt_val),
    .we_i(ctrl.reg_write), .wa_i(wb_addr), .wd_i(wb_data)
  );

  assign alu_b = ctrl.alu_src ? imm_sext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .ctrl_i(alu_ctrl), .a_i(rs_val), .b_i(alu_b), .y_o(alu_y), .zero_o(alu_zero)
  );

  logic [XLEN-1:0] dmem_raw;
  sc_mem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk_i, .addr_i(alu_y), .we_i(ctrl.mem_write), .wdata_i(rt_val), .rdata_o(dmem_raw)
  );
  assign mem_rd = ctrl.mem_read ? dmem_raw : '0;

  assign wb_addr = ctrl.reg_dst ? rd : rt;
  assign wb_data = ctrl.mem_to_reg ? mem_rd : alu_y;

  // next-PC selection
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
  assign j_tgt    = {pc_q[XLEN-1:XLEN-4], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                    pc_next = j_tgt;
    else if (ctrl.branch && alu_zero) pc_next = br_tgt;
    else                              pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o      = pc_q;
  assign wb_en_o   = ctrl.reg_write && (wb_addr != '0);
  assign wb_addr_o = wb_addr;
  assign wb_data_o = wb_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_o,
  input logic        wb_en_o,
  input logic [4:0]  wb_addr_o,
  input logic [31:0] instr_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] rt_val_i
);
  logic [5:0]  op;
  logic [31:0] boff;
  assign op   = instr_i[31:26];
  assign boff = {{14{instr_i[15]}}, instr_i[15:0], 2'b00};

  AST_PC_RESET: assert property (@(posedge clk_i) !rst_ni |-> pc_o == 32'd0);  // R1

  AST_PC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);  // R2

  AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 6'd4 && op != 6'd2) |=> pc_o == $past(pc_o) + 32'd4);  // R2

  AST_R0_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_addr_o != 5'd0);  // R8

  AST_LOAD_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'd35 && wb_en_o) |-> wb_addr_o == instr_i[20:16]);  // R4

  AST_STORE_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == 6'd43 |-> !wb_en_o);  // R5

  AST_BEQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'd4 && rs_val_i == rt_val_i) |=> pc_o == $past(pc_o) + 32'd4 + $past(boff));  // R6

  AST_BEQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'd4 && rs_val_i != rt_val_i) |=> pc_o == $past(pc_o) + 32'd4);  // R6

  AST_JUMP_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == 6'd2 |=> pc_o == {$past(pc_o[31:28]), $past(instr_i[25:0]), 2'b00});  // R7

  AST_NOP_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 6'd0 && op != 6'd35) |-> !wb_en_o);  // R9
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pc_o     (pc_o),
  .wb_en_o  (wb_en_o),
  .wb_addr_o(wb_addr_o),
  .instr_i  (instr),
  .rs_val_i (rs_val),
  .rt_val_i (rt_val)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
  localparam int NPAIR = 8;
  localparam int NCYC  = 170;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_o, wb_data_o;
  logic        wb_en_o;
  logic [4:0]  wb_addr_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sc_core u_sc_core (
    .clk_i(clk), .rst_ni, .pc_o, .wb_en_o, .wb_addr_o, .wb_data_o
  );

  logic [31:0] prog [64];
  logic [31:0] m_dmem [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_pc;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pc=%0h actual=%0h expected=%0h", req, m_pc, act, exp);
    end
  endtask

  // reference model: compare outputs for the instruction at m_pc, then retire it
  task automatic step_and_check();
    logic [31:0] ins, a, b, sx, y, nxt;
    logic [5:0]  op, fn;
    logic        we;
    int          dst;
    string       tag;
    ins = prog[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    a = m_reg[ins[25:21]]; b = m_reg[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    we = 1'b0; dst = 0; y = 0; nxt = m_pc + 4; tag = "R9";
    case (op)
      6'd0: begin
        tag = "R3"; we = 1'b1; dst = ins[15:11];
        case (fn)
          6'h22: y = a - b;
          6'h24: y = a & b;
          6'h25: y = a | b;
          6'h2A: y = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: y = a + b;
        endcase
      end
      6'd35: begin tag = "R4"; we = 1'b1; dst = ins[20:16]; y = m_dmem[(a + sx) >> 2 & 63]; end
      6'd43: begin tag = "R5"; m_dmem[(a + sx) >> 2 & 63] = b; end
      6'd4:  begin tag = "R6"; if (a == b) nxt = m_pc + 4 + (sx << 2); end
      6'd2:  begin tag = "R7"; nxt = {m_pc[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (dst == 0) begin
      if (we) tag = "R8";
      we = 1'b0;
    end
    check("R2", pc_o, m_pc);
    check(tag, {31'd0, wb_en_o}, {31'd0, we});
    if (we) begin
      check("R10", {27'd0, wb_addr_o}, 32'(dst));
      check(tag, wb_data_o, y);
      m_reg[dst] = y;
    end
    m_pc = nxt;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin prog[i] = 32'hFC00_0000; m_dmem[i] = 32'd0; end
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    // operand sweep: equal pairs, negatives, extremes
    for (int i = 0; i < NPAIR; i++) begin
      m_dmem[2*i]   = 32'((i - 4) * 123456789);
      m_dmem[2*i+1] = (i % 3 == 0) ? m_dmem[2*i] : 32'((3 - i) * 987654321);
    end
    m_dmem[60] = 32'd8;
    m_dmem[61] = 32'(8 * NPAIR);
    prog[0]  = enc_i(6'd35, 0, 11, 240);
    prog[1]  = enc_i(6'd35, 0, 12, 244);
    prog[2]  = enc_i(6'd35, 10, 1, 0);
    prog[3]  = enc_i(6'd35, 10, 2, 4);
    prog[4]  = enc_r(1, 2, 3, 6'h20);
    prog[5]  = enc_r(1, 2, 4, 6'h22);
    prog[6]  = enc_r(1, 2, 5, 6'h24);
    prog[7]  = enc_r(1, 2, 6, 6'h25);
    prog[8]  = enc_r(1, 2, 7, 6'h2A);
    prog[9]  = enc_i(6'd43, 10, 3, 128);
    prog[10] = enc_i(6'd35, 10, 8, 128);
    prog[11] = enc_i(6'd4, 1, 2, 1);
    prog[12] = enc_r(9, 1, 9, 6'h20);   // read and write r9 in one cycle
    prog[13] = enc_r(1, 2, 0, 6'h20);   // write to r0 dropped
    prog[14] = enc_r(10, 11, 10, 6'h20);
    prog[15] = enc_i(6'd4, 10, 12, 1);
    prog[16] = {6'd2, 26'd2};
    prog[17] = 32'hFC00_0000;           // unknown opcode
    prog[18] = enc_i(6'd43, 12, 9, -4);
    prog[19] = enc_i(6'd35, 12, 13, -4);
    prog[20] = enc_i(6'd4, 0, 0, -1);   // self loop
    for (int i = 0; i < 64; i++) begin
      u_sc_core.u_imem.mem_q[i] = prog[i];
      u_sc_core.u_dmem.mem_q[i] = m_dmem[i];
    end
    m_pc = 32'd0;
    repeat (3) @(negedge clk);
    check("R1", pc_o, 32'd0);
    rst_ni = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      step_and_check();
      @(negedge clk);
    end
    check("R8", m_reg[0], 32'd0);
    check("R2", pc_o, 32'd80);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule